// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This unit watches a vector of already-synchronized GPIO pin inputs and turns selected pin activity into one interrupt request. Every pin has its own trigger setting built from three independent bits: a kind bit (edge or level), a sense bit (high/rising or low/falling) and a two-way bit that, in edge mode, accepts either transition. Edge events are captured into a sticky status bit. Level status tracks the pin as it is. Software sees the raw status and the status after the enable and mask gates, and it acknowledges captured edges by writing ones to a clear register.

A per-pin input filter is optional. When a pin's filter bit is set, that pin is resampled only on ticks of a shared divider whose period is set by a prescale register. A pin that changes between ticks is therefore not seen. The register interface is a plain single-cycle write strobe with a combinational read path.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register reads 0, raw status (0x24) and gated status (0x28) read 0, and `irq_o` is low.
- R2: Configuration registers read back what was written, at these offsets: enable 0x20, mask 0x2C, kind 0x34, two-way 0x38, sense 0x3C, filter enable 0x40, prescale 0x44 (low 16 bits). The clear register 0x30 reads 0.
- R3: With kind bit 0 (edge), an enabled pin whose sense bit is 0 latches raw status on a 0-to-1 change. With sense bit 1 it latches on a 1-to-0 change. A disabled pin never latches. For an unfiltered pin, the status is visible two clock edges after the pin changes.
- R4: In edge mode, a two-way bit of 1 latches on either transition, whatever the sense bit holds.
- R5: With kind bit 1 (level), the raw status bit equals the filtered pin XOR its sense bit, one edge after the pin changes, whether or not the pin is enabled.
- R6: Writing 0x30 clears the latched edge status of each bit written as 1. Bits written as 0 keep their status.
- R7: When a new edge event and a clear for the same pin happen in the same cycle, the status stays set.
- R8: Gated status equals raw status AND enable AND NOT mask. Writing 0 to the mask unmasks every pin. Clearing an enable bit does not erase latched raw status.
- R9: `irq_o` is a register that goes high one clock edge after any gated status bit is set, and low one edge after all are clear.
- R10: A write to the prescale register restarts the divider at 0. A filtered pin is resampled only at the edge that closes a cycle in which the divider equals the prescale value, so a pulse lasting between ticks is not seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Register byte offset |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, combinational |
| pins_in | input | NPINS (32) | Synchronized pin inputs |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands in exactly the cycle when a new edge is being captured on the same pin. The bench latches a pin, lets it fall (which does not trigger in rising mode), raises it again, and places the clear strobe on the next edge, where the registered sample has just risen. The filter window is also hard to reach from the ports. The bench writes the prescale value so that the divider phase is known, then moves a pin just after a tick and checks that it is not seen until the next one. It also applies a pulse that falls wholly between ticks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [7:0] {
      OFS_ENABLE   = 8'h20,
      OFS_RAW      = 8'h24,
      OFS_GATED    = 8'h28,
      OFS_MASK     = 8'h2C,
      OFS_CLEAR    = 8'h30,
      OFS_KIND     = 8'h34,
      OFS_TWOWAY   = 8'h38,
      OFS_SENSE    = 8'h3C,
      OFS_FILT_EN  = 8'h40,
      OFS_PRESCALE = 8'h44
   } reg_ofs_e;

   localparam int MIN_ADDR_W = 7;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
   import gpio_irq_pkg::*;
#(
   parameter int NPINS = 32,
   parameter int DW    = 32,
   parameter int AW    = 8,
   parameter int PS_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [NPINS-1:0] en,
   output logic [NPINS-1:0] msk,
   output logic [NPINS-1:0] kind,
   output logic [NPINS-1:0] sense,
   output logic [NPINS-1:0] twoway,
   output logic [NPINS-1:0] filt_en,
   output logic [PS_W-1:0]  prescale,
   output logic [NPINS-1:0] clr,
   output logic             ps_wr
);

   logic [NPINS-1:0] wbits;
   assign wbits = wdata[NPINS-1:0];

   generate
      if (DW > NPINS && DW > PS_W) begin : g_hi
         localparam int LOW = (NPINS > PS_W) ? NPINS : PS_W;
         logic unused_hi;
         assign unused_hi = ^wdata[DW-1:LOW];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= '0;
         msk      <= '0;
         kind     <= '0;
         sense    <= '0;
         twoway   <= '0;
         filt_en  <= '0;
         prescale <= '0;
      end else if (we) begin
         if (addr == AW'(OFS_ENABLE))   en       <= wbits;
         if (addr == AW'(OFS_MASK))     msk      <= wbits;
         if (addr == AW'(OFS_KIND))     kind     <= wbits;
         if (addr == AW'(OFS_SENSE))    sense    <= wbits;
         if (addr == AW'(OFS_TWOWAY))   twoway   <= wbits;
         if (addr == AW'(OFS_FILT_EN))  filt_en  <= wbits;
         if (addr == AW'(OFS_PRESCALE)) prescale <= wdata[PS_W-1:0];
      end
   end

   assign clr   = (we && addr == AW'(OFS_CLEAR)) ? wbits : '0;
   assign ps_wr = we && (addr == AW'(OFS_PRESCALE));

endmodule

// File: rtl/gpio_irq_sampler.sv
module gpio_irq_sampler #(
   parameter int NPINS        = 32,
   parameter int PS_W         = 16,
   parameter bit HAS_DEBOUNCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins,
   input  logic [NPINS-1:0] filt_en,
   input  logic [PS_W-1:0]  prescale,
   input  logic             ps_wr,
   output logic [NPINS-1:0] filt
);

   logic [NPINS-1:0] filt_q;
   assign filt = filt_q;

   generate
      if (HAS_DEBOUNCE) begin : g_deb
         logic [PS_W-1:0]  cnt_q;
         logic             tick;
         logic [NPINS-1:0] take;

         assign tick = (cnt_q == prescale);
         assign take = ~filt_en | {NPINS{tick}};

         always_ff @(posedge clk) begin
            if (!rst_n)           cnt_q <= '0;
            else if (ps_wr||tick) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) filt_q <= '0;
            else        filt_q <= (pins & take) | (filt_q & ~take);
         end

         // R10: the divider restarts after a prescale write
         p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ps_wr |=> (cnt_q == '0));

         for (genvar i = 0; i < NPINS; i++) begin : g_chk
            // R10: a filtered pin holds its sample between ticks
            p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
               (filt_en[i] && !tick) |=> $stable(filt_q[i]));
         end
      end else begin : g_direct
         logic unused_cfg;
         assign unused_cfg = ^{filt_en, prescale, ps_wr};

         always_ff @(posedge clk) begin
            if (!rst_n) filt_q <= '0;
            else        filt_q <= pins;
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] filt,
   input  logic [NPINS-1:0] en,
   input  logic [NPINS-1:0] kind,
   input  logic [NPINS-1:0] sense,
   input  logic [NPINS-1:0] twoway,
   input  logic [NPINS-1:0] clr,
   output logic [NPINS-1:0] raw
);

   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] lat_q;
   logic [NPINS-1:0] rise, fall, evt, set;

   assign rise = filt & ~prev_q;
   assign fall = ~filt & prev_q;
   assign evt  = (twoway & (rise | fall))
               | (~twoway & ((~sense & rise) | (sense & fall)));
   assign set  = evt & en & ~kind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         lat_q  <= '0;
      end else begin
         prev_q <= filt;
         lat_q  <= set | (lat_q & ~clr);
      end
   end

   assign raw = (kind & (filt ^ sense)) | (~kind & lat_q);

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_chk
         // R7: a new event beats a clear in the same cycle
         p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && !kind[i] && clr[i] && (filt[i] != prev_q[i])
             && (twoway[i] || (filt[i] != sense[i]))) |=> lat_q[i]);
         // R6: latched status only leaves through a clear
         p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q[i] && !clr[i]) |=> lat_q[i]);
         // R3: a disabled pin never latches
         p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!lat_q[i] && !en[i]) |=> !lat_q[i]);
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int NPINS        = 32,
   parameter int DW           = 32,
   parameter int AW           = 8,
   parameter int PS_W         = 16,
   parameter bit HAS_DEBOUNCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [AW-1:0]    reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic [NPINS-1:0] pins_in,
   output logic             irq_o
);

   generate
      if (NPINS < 1 || NPINS > DW) begin : g_bad_npins
         $error("gpio_irq_unit: NPINS must lie in 1..DW");
      end
      if (PS_W < 1 || PS_W > DW) begin : g_bad_psw
         $error("gpio_irq_unit: PS_W must lie in 1..DW");
      end
      if (AW < MIN_ADDR_W) begin : g_bad_aw
         $error("gpio_irq_unit: AW too narrow for the register offsets");
      end
   endgenerate

   logic [NPINS-1:0] en, msk, kind, sense, twoway, filt_en, clr;
   logic [NPINS-1:0] filt, raw, gated;
   logic [PS_W-1:0]  prescale;
   logic             ps_wr;
   logic             irq_q;

   gpio_irq_cfg #(.NPINS(NPINS), .DW(DW), .AW(AW), .PS_W(PS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .en(en), .msk(msk), .kind(kind), .sense(sense), .twoway(twoway),
      .filt_en(filt_en), .prescale(prescale), .clr(clr), .ps_wr(ps_wr)
   );

   gpio_irq_sampler #(.NPINS(NPINS), .PS_W(PS_W), .HAS_DEBOUNCE(HAS_DEBOUNCE)) u_smp (
      .clk(clk), .rst_n(rst_n), .pins(pins_in), .filt_en(filt_en),
      .prescale(prescale), .ps_wr(ps_wr), .filt(filt)
   );

   gpio_irq_detect #(.NPINS(NPINS)) u_det (
      .clk(clk), .rst_n(rst_n), .filt(filt), .en(en), .kind(kind),
      .sense(sense), .twoway(twoway), .clr(clr), .raw(raw)
   );

   assign gated = raw & en & ~msk;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |gated;
   end
   assign irq_o = irq_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == AW'(OFS_ENABLE))   reg_rdata[NPINS-1:0] = en;
      if (reg_addr == AW'(OFS_RAW))      reg_rdata[NPINS-1:0] = raw;
      if (reg_addr == AW'(OFS_GATED))    reg_rdata[NPINS-1:0] = gated;
      if (reg_addr == AW'(OFS_MASK))     reg_rdata[NPINS-1:0] = msk;
      if (reg_addr == AW'(OFS_KIND))     reg_rdata[NPINS-1:0] = kind;
      if (reg_addr == AW'(OFS_TWOWAY))   reg_rdata[NPINS-1:0] = twoway;
      if (reg_addr == AW'(OFS_SENSE))    reg_rdata[NPINS-1:0] = sense;
      if (reg_addr == AW'(OFS_FILT_EN))  reg_rdata[NPINS-1:0] = filt_en;
      if (reg_addr == AW'(OFS_PRESCALE)) reg_rdata[PS_W-1:0]  = prescale;
   end

   // R9: request follows the gated status one edge later
   p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|gated) |=> irq_o);
   p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(|gated) |=> !irq_o);

endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] pins_in = '0;
   logic        irq_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins_in(pins_in), .irq_o(irq_o)
   );

   typedef struct packed {
      logic [6:0] pins;
      logic [6:0] raw;
      logic [6:0] gated;
      logic       irq;
   } vec_t;

   // pin0 rising, pin1 falling, pin2 either, pin3 level high, pin4 level low,
   // pin5 rising but disabled, pin6 rising but masked
   localparam vec_t VEC [12] = '{
      '{7'h00, 7'h10, 7'h10, 1'b1},
      '{7'h7F, 7'h4D, 7'h0D, 1'b1},
      '{7'h00, 7'h16, 7'h16, 1'b1},
      '{7'h18, 7'h08, 7'h08, 1'b1},
      '{7'h58, 7'h48, 7'h08, 1'b1},
      '{7'h50, 7'h00, 7'h00, 1'b0},
      '{7'h54, 7'h04, 7'h04, 1'b1},
      '{7'h50, 7'h04, 7'h04, 1'b1},
      '{7'h51, 7'h01, 7'h01, 1'b1},
      '{7'h53, 7'h00, 7'h00, 1'b0},
      '{7'h51, 7'h02, 7'h02, 1'b1},
      '{7'h71, 7'h00, 7'h00, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h24, v); check("R1 raw", v, 0);
      rd(8'h28, v); check("R1 gated", v, 0);
      rd(8'h20, v); check("R1 enable", v, 0);
      rd(8'h44, v); check("R1 prescale", v, 0);
      check("R1 irq", {31'd0, irq_o}, 0);

      // R2 configuration and readback
      wr(8'h20, 32'h5F);
      wr(8'h2C, 32'h40);
      wr(8'h34, 32'h18);
      wr(8'h3C, 32'h12);
      wr(8'h38, 32'h04);
      rd(8'h20, v); check("R2 enable", v, 32'h5F);
      rd(8'h2C, v); check("R2 mask", v, 32'h40);
      rd(8'h34, v); check("R2 kind", v, 32'h18);
      rd(8'h3C, v); check("R2 sense", v, 32'h12);
      rd(8'h38, v); check("R2 twoway", v, 32'h04);
      rd(8'h30, v); check("R2 clear reads 0", v, 0);
      wr(8'h30, 32'hFFFF_FFFF);

      // R3 R4 R5 R8 R9 table walk
      for (int k = 0; k < 12; k++) begin
         pins_in = {25'd0, VEC[k].pins};
         cycles(3);
         rd(8'h24, v); check($sformatf("R3/R4/R5 raw step %0d", k), v, {25'd0, VEC[k].raw});
         rd(8'h28, v); check($sformatf("R8 gated step %0d", k), v, {25'd0, VEC[k].gated});
         check($sformatf("R9 irq step %0d", k), {31'd0, irq_o}, {31'd0, VEC[k].irq});
         wr(8'h30, 32'hFFFF_FFFF);
      end

      // R6 partial clear
      pins_in = 32'h70; cycles(3); wr(8'h30, 32'hFFFF_FFFF);
      pins_in = 32'h75; cycles(3);
      wr(8'h30, 32'h01);
      rd(8'h24, v); check("R6 zero bits keep status", v, 32'h04);

      // R7 edge and clear in the same cycle
      pins_in = 32'h74; cycles(3);
      pins_in = 32'h75;
      @(posedge clk); @(negedge clk);
      wr(8'h30, 32'h01);
      rd(8'h24, v); check("R7 event beats clear", v, 32'h05);
      wr(8'h30, 32'h01);
      rd(8'h24, v); check("R6 clear without event", v, 32'h04);

      // R8 mask zero, enable removal keeps raw
      wr(8'h2C, 32'h0);
      rd(8'h28, v); check("R8 unmasked gated", v, 32'h04);
      wr(8'h20, 32'h0);
      rd(8'h28, v); check("R8 disabled gated", v, 0);
      rd(8'h24, v); check("R8 raw kept", v, 32'h04);
      cycles(1);
      check("R9 irq low", {31'd0, irq_o}, 0);
      wr(8'h20, 32'h04);
      check("R9 irq one edge late", {31'd0, irq_o}, 0);
      cycles(1);
      check("R9 irq high", {31'd0, irq_o}, 1);

      // R10 input filter
      wr(8'h20, 32'h5F);
      pins_in = 32'h74; cycles(3);
      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'h40, 32'h01);
      wr(8'h44, 32'h03);
      pins_in = 32'h75;
      cycles(3);
      rd(8'h24, v); check("R10 held between ticks", v & 32'h1, 0);
      cycles(2);
      rd(8'h24, v); check("R10 seen after tick", v & 32'h1, 1);
      rd(8'h40, v); check("R2 filter enable", v, 32'h01);
      rd(8'h44, v); check("R2 prescale", v, 32'h03);
      wr(8'h30, 32'hFFFF_FFFF);
      pins_in = 32'h74;
      @(posedge clk); @(negedge clk);
      pins_in = 32'h75;
      cycles(8);
      rd(8'h24, v); check("R10 short pulse ignored", v, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule